// File: doc/BRIEF.md
# Memory Operand Effective Address Generator

This block turns an addressing-mode byte into the 16-bit offset of a memory operand. It takes the 2-bit mode field, the 3-bit register/memory selector, up to two displacement bytes, and the current values of the two base registers (BX, BP) and the two index registers (SI, DI). From these it produces the effective address, a flag that marks a register operand (no memory access), and a hint that says which segment the address defaults to: stack or data.

The mode picks the displacement size: none, one sign-extended byte, or a full 16-bit word. The selector picks a base-plus-index pair or a single pointer register. One exception applies. With mode 00 and selector 110 the block ignores the registers and uses the two displacement bytes as a direct address. Adding the segment base, the memory access itself and reading the register file are done outside this block.

The result is registered. A valid-in strobe gives a valid-out strobe on the next clock. The outputs keep their value while no new request arrives.

Top module: `opnd_addr_gen`

## Requirements
- R1: When mode is 11 (register operand), one cycle later `reg_opnd_o` is 1, `ea_o` is 0 and `stack_seg_o` is 0. For every other mode `reg_opnd_o` is 0.
- R2: When mode is 00 and the selector is not 110, no displacement is added: `ea_o` is the register sum alone.
- R3: When mode is 00 and the selector is 110, `ea_o` equals {disp_hi_i, disp_lo_i}. The registers do not affect it, and `stack_seg_o` is 0.
- R4: When mode is 01, the displacement is `disp_lo_i` sign-extended from bit 7, and `disp_hi_i` has no effect.
- R5: When mode is 10, the displacement is {disp_hi_i, disp_lo_i}.
- R6: Selector codes 000, 001, 010 and 011 give BX+SI, BX+DI, BP+SI and BP+DI, plus the displacement.
- R7: Selector codes 100, 101, 110 and 111 give SI, DI, BP and BX, plus the displacement.
- R8: All sums wrap modulo 2^16. Carries out of bit 15 are dropped.
- R9: `stack_seg_o` is 1 exactly when a memory mode (00, 01, 10) uses BP as its base (selector 010, 011 or 110) and the direct case of R3 does not apply. Otherwise it is 0 (data segment).
- R10: `out_valid` equals `in_valid` of the previous clock. A synchronous active-low reset drives `out_valid`, `ea_o`, `reg_opnd_o` and `stack_seg_o` to 0.
- R11: In a cycle where `in_valid` is 0, `ea_o`, `reg_opnd_o` and `stack_seg_o` keep their previous values, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Request strobe: the mode, selector, displacement and register inputs are valid |
| mode_i | input | 2 | Addressing mode field |
| rm_i | input | 3 | Register/memory selector field |
| disp_lo_i | input | 8 | Low displacement byte |
| disp_hi_i | input | 8 | High displacement byte |
| bx_i | input | 16 | Current BX value |
| bp_i | input | 16 | Current BP value |
| si_i | input | 16 | Current SI value |
| di_i | input | 16 | Current DI value |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| ea_o | output | 16 | Effective address (offset within the segment) |
| reg_opnd_o | output | 1 | Operand is a register, not memory |
| stack_seg_o | output | 1 | 1 selects the stack segment by default, 0 the data segment |

## Verification
Every result (address, register flag, segment hint and valid strobe) is due exactly one rising edge after the inputs that produced it. Held outputs must stay unchanged through every later edge in which `in_valid` is low.

The bench drives new inputs on the falling edge. At each falling edge, before it drives, it compares all four outputs with a behavioural model. The model updates on the rising edge, so every comparison falls half a period after the edge that made the result.

Directed sweeps cover every mode and selector pair, both signs of the short displacement, and register values that force a wrap. Random traffic with idle gaps follows.

// File: rtl/opnd_addr_pkg.sv
// Shared encodings for the operand address generator.
// Assumes: the mode field is 2 bits and the selector field is 3 bits. The
// code values below are what the decoder relies on.
package opnd_addr_pkg;

    typedef enum logic [1:0] {
        MOD_NODISP = 2'b00,
        MOD_DISP8  = 2'b01,
        MOD_DISP16 = 2'b10,
        MOD_REG    = 2'b11
    } addr_mode_e;

    typedef enum logic [2:0] {
        RM_BX_SI = 3'd0,
        RM_BX_DI = 3'd1,
        RM_BP_SI = 3'd2,
        RM_BP_DI = 3'd3,
        RM_SI    = 3'd4,
        RM_DI    = 3'd5,
        RM_BP    = 3'd6,
        RM_BX    = 3'd7
    } rm_sel_e;

endpackage

// File: rtl/opnd_disp_sel.sv
// Displacement selector: builds the displacement term from the mode field.
// It also flags the direct-address case (mode 00, selector 110), where the
// two displacement bytes form the whole address.
// Assumes: ADDR_W is even. Each displacement byte is half an address wide.
module opnd_disp_sel
    import opnd_addr_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic [1:0]          mode_i,
    input  logic [2:0]          rm_i,
    input  logic [ADDR_W/2-1:0] disp_lo_i,
    input  logic [ADDR_W/2-1:0] disp_hi_i,
    output logic [ADDR_W-1:0]   disp_o,
    output logic                direct_o
);
    localparam int BYTE_W = ADDR_W / 2;
    localparam int EXT_W  = ADDR_W - BYTE_W;

    // Detect the direct-address exception.
    always_comb begin
        direct_o = (addr_mode_e'(mode_i) == MOD_NODISP) && (rm_sel_e'(rm_i) == RM_BP);
    end

    // Choose the displacement width for the current mode.
    always_comb begin
        unique case (addr_mode_e'(mode_i))
            MOD_NODISP: disp_o = direct_o ? {disp_hi_i, disp_lo_i} : '0;
            MOD_DISP8:  disp_o = {{EXT_W{disp_lo_i[BYTE_W-1]}}, disp_lo_i};
            MOD_DISP16: disp_o = {disp_hi_i, disp_lo_i};
            default:    disp_o = '0;
        endcase
    end
endmodule

// File: rtl/opnd_base_sel.sv
// Base/index selector: picks the base and index operands from the selector
// field and produces the default-segment hint.
// Assumes: unused operands are driven to zero, so the adder always sums three
// terms. In the register mode and the direct case both operands are zero.
module opnd_base_sel
    import opnd_addr_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic [1:0]        mode_i,
    input  logic [2:0]        rm_i,
    input  logic              direct_i,
    input  logic [ADDR_W-1:0] bx_i,
    input  logic [ADDR_W-1:0] bp_i,
    input  logic [ADDR_W-1:0] si_i,
    input  logic [ADDR_W-1:0] di_i,
    output logic [ADDR_W-1:0] base_o,
    output logic [ADDR_W-1:0] index_o,
    output logic              stack_o
);
    logic mem_mode;

    // A memory operand needs a mode other than the register mode and no direct address.
    always_comb begin
        mem_mode = (addr_mode_e'(mode_i) != MOD_REG) && !direct_i;
    end

    // Route the registers named by the selector onto the base and index operands.
    always_comb begin
        base_o  = '0;
        index_o = '0;
        stack_o = 1'b0;
        if (mem_mode) begin
            unique case (rm_sel_e'(rm_i))
                RM_BX_SI: begin base_o = bx_i; index_o = si_i; end
                RM_BX_DI: begin base_o = bx_i; index_o = di_i; end
                RM_BP_SI: begin base_o = bp_i; index_o = si_i; stack_o = 1'b1; end
                RM_BP_DI: begin base_o = bp_i; index_o = di_i; stack_o = 1'b1; end
                RM_SI:    begin index_o = si_i; end
                RM_DI:    begin index_o = di_i; end
                RM_BP:    begin base_o = bp_i; stack_o = 1'b1; end
                default:  begin base_o = bx_i; end
            endcase
        end
    end
endmodule

// File: rtl/opnd_sum3.sv
// Three-operand modulo adder: one carry-save row, then one carry-propagate add.
// The carry out of the top bit is not formed, so the result wraps modulo 2^ADDR_W.
// Assumes: ADDR_W >= 2.
module opnd_sum3 #(
    parameter int ADDR_W = 16
) (
    input  logic [ADDR_W-1:0] a_i,
    input  logic [ADDR_W-1:0] b_i,
    input  logic [ADDR_W-1:0] c_i,
    output logic [ADDR_W-1:0] sum_o
);
    logic [ADDR_W-1:0] save_sum;
    logic [ADDR_W-1:0] save_cry;

    assign save_cry[0] = 1'b0;

    for (genvar i = 0; i < ADDR_W; i++) begin : g_csa
        // Bitwise sum of the three operands.
        assign save_sum[i] = a_i[i] ^ b_i[i] ^ c_i[i];
        if (i < ADDR_W - 1) begin : g_cry
            // Majority carry, shifted one bit up; the top carry is dropped.
            assign save_cry[i+1] = (a_i[i] & b_i[i]) | (a_i[i] & c_i[i]) | (b_i[i] & c_i[i]);
        end
    end

    // Final carry-propagate add, truncated to the address width.
    always_comb begin
        sum_o = save_sum + save_cry;
    end
endmodule

// File: rtl/opnd_addr_gen.sv
// Operand effective address generator (top).
// It decodes the mode and selector fields, adds base, index and displacement
// modulo 2^ADDR_W, and registers the address, the register-operand flag and
// the stack-segment hint. Latency is one clock. The outputs load only when
// in_valid is high and otherwise hold.
// Assumes: register values are stable with in_valid. Reset is synchronous and active low.
module opnd_addr_gen
    import opnd_addr_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [1:0]          mode_i,
    input  logic [2:0]          rm_i,
    input  logic [ADDR_W/2-1:0] disp_lo_i,
    input  logic [ADDR_W/2-1:0] disp_hi_i,
    input  logic [ADDR_W-1:0]   bx_i,
    input  logic [ADDR_W-1:0]   bp_i,
    input  logic [ADDR_W-1:0]   si_i,
    input  logic [ADDR_W-1:0]   di_i,
    output logic                out_valid,
    output logic [ADDR_W-1:0]   ea_o,
    output logic                reg_opnd_o,
    output logic                stack_seg_o
);
    localparam int BYTE_W = ADDR_W / 2;
    localparam int EXT_W  = ADDR_W - BYTE_W;

    logic [ADDR_W-1:0] disp;
    logic              direct;
    logic [ADDR_W-1:0] base;
    logic [ADDR_W-1:0] index;
    logic              stack_hint;
    logic [ADDR_W-1:0] ea_next;
    logic              reg_next;

    opnd_disp_sel #(.ADDR_W(ADDR_W)) u_disp (
        .mode_i   (mode_i),
        .rm_i     (rm_i),
        .disp_lo_i(disp_lo_i),
        .disp_hi_i(disp_hi_i),
        .disp_o   (disp),
        .direct_o (direct)
    );

    opnd_base_sel #(.ADDR_W(ADDR_W)) u_base (
        .mode_i  (mode_i),
        .rm_i    (rm_i),
        .direct_i(direct),
        .bx_i    (bx_i),
        .bp_i    (bp_i),
        .si_i    (si_i),
        .di_i    (di_i),
        .base_o  (base),
        .index_o (index),
        .stack_o (stack_hint)
    );

    opnd_sum3 #(.ADDR_W(ADDR_W)) u_sum (
        .a_i  (base),
        .b_i  (index),
        .c_i  (disp),
        .sum_o(ea_next)
    );

    // Flag the register-operand mode.
    always_comb begin
        reg_next = (addr_mode_e'(mode_i) == MOD_REG);
    end

    // Track the request strobe with one cycle of latency.
    always_ff @(posedge clk) begin
        if (!rst_n) out_valid <= 1'b0;
        else        out_valid <= in_valid;
    end

    // Capture the result on a request and hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ea_o        <= '0;
            reg_opnd_o  <= 1'b0;
            stack_seg_o <= 1'b0;
        end else if (in_valid) begin
            ea_o        <= ea_next;
            reg_opnd_o  <= reg_next;
            stack_seg_o <= stack_hint;
        end
    end

    // R10
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (out_valid == $past(in_valid)));

    // R1
    reg_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode_i == 2'b11) |=> (reg_opnd_o && ea_o == '0 && !stack_seg_o));

    // R3
    direct_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode_i == 2'b00 && rm_i == 3'b110)
        |=> (ea_o == {$past(disp_hi_i), $past(disp_lo_i)} && !stack_seg_o && !reg_opnd_o));

    // R4
    short_disp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode_i == 2'b01 && rm_i == 3'b111)
        |=> (ea_o == ADDR_W'($past(bx_i)
              + {{EXT_W{$past(disp_lo_i[BYTE_W-1])}}, $past(disp_lo_i)})));

    // R11
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(ea_o) && $stable(reg_opnd_o) && $stable(stack_seg_o)));

    // R9
    seg_reg_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_opnd_o |-> !stack_seg_o);
endmodule

// File: tb/test_opnd_addr_gen.sv
`timescale 1ns/1ps
// Bench for opnd_addr_gen. A behavioural model updates on each rising edge.
// All outputs are compared with the model on each falling edge.
module test_opnd_addr_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        iv = 1'b0;
    logic [1:0]  md = '0;
    logic [2:0]  rm = '0;
    logic [7:0]  dlo = '0, dhi = '0;
    logic [15:0] rbx = '0, rbp = '0, rsi = '0, rdi = '0;
    logic        ov, reg_f, stk_f;
    logic [15:0] ea;

    int checks = 0;
    int fails  = 0;
    bit chk_on = 1'b0;
    bit done   = 1'b0;

    logic        m_v = 1'b0, m_reg = 1'b0, m_stk = 1'b0;
    logic [15:0] m_ea = '0;
    string       m_tag = "R10";

    always #4 clk = ~clk;

    opnd_addr_gen i_opnd_addr_gen (
        .clk(clk), .rst_n(rst_n), .in_valid(iv), .mode_i(md), .rm_i(rm),
        .disp_lo_i(dlo), .disp_hi_i(dhi), .bx_i(rbx), .bp_i(rbp), .si_i(rsi), .di_i(rdi),
        .out_valid(ov), .ea_o(ea), .reg_opnd_o(reg_f), .stack_seg_o(stk_f)
    );

    // Reference model.
    always @(posedge clk) begin
        int disp, total;
        if (!rst_n) begin
            m_v = 0; m_ea = '0; m_reg = 0; m_stk = 0; m_tag = "R10";
        end else begin
            m_v = iv;
            if (!iv) m_tag = "R11";
            else if (md == 2'd3) begin
                m_reg = 1; m_ea = '0; m_stk = 0; m_tag = "R1";
            end else if (md == 2'd0 && rm == 3'd6) begin
                m_reg = 0; m_ea = {dhi, dlo}; m_stk = 0; m_tag = "R3";
            end else begin
                if (md == 2'd0)      begin disp = 0; m_tag = "R2"; end
                else if (md == 2'd1) begin disp = (dlo >= 128) ? int'(dlo) - 256 : int'(dlo); m_tag = "R4"; end
                else                 begin disp = int'(dhi) * 256 + int'(dlo); m_tag = "R5"; end
                case (rm)
                    3'd0: total = int'(rbx) + int'(rsi);
                    3'd1: total = int'(rbx) + int'(rdi);
                    3'd2: total = int'(rbp) + int'(rsi);
                    3'd3: total = int'(rbp) + int'(rdi);
                    3'd4: total = int'(rsi);
                    3'd5: total = int'(rdi);
                    3'd6: total = int'(rbp);
                    default: total = int'(rbx);
                endcase
                m_tag = {m_tag, (rm < 3'd4) ? "/R6" : "/R7"};
                total = total + disp;
                if (total > 65535 || total < 0) m_tag = {m_tag, "/R8"};
                m_ea  = total[15:0];
                m_reg = 0;
                m_stk = (rm == 3'd2 || rm == 3'd3 || rm == 3'd6);
            end
        end
    end

    // Compare all outputs half a period after each rising edge.
    always @(negedge clk) begin
        if (chk_on && !done) begin
            checks += 4;
            if (ov !== m_v) begin fails++; $display("FAIL R10 out_valid got %b exp %b", ov, m_v); end
            if (ea !== m_ea) begin fails++; $display("FAIL %s ea got %h exp %h", m_tag, ea, m_ea); end
            if (reg_f !== m_reg) begin fails++; $display("FAIL R1 reg_opnd got %b exp %b (%s)", reg_f, m_reg, m_tag); end
            if (stk_f !== m_stk) begin fails++; $display("FAIL R9 stack_seg got %b exp %b (%s)", stk_f, m_stk, m_tag); end
        end
    end

    task automatic step(input logic v, input logic [1:0] m, input logic [2:0] r,
                        input logic [7:0] lo, input logic [7:0] hi);
        @(negedge clk);
        iv = v; md = m; rm = r; dlo = lo; dhi = hi;
    endtask

    task automatic regs(input logic [15:0] b, input logic [15:0] p,
                        input logic [15:0] s, input logic [15:0] d);
        rbx = b; rbp = p; rsi = s; rdi = d;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        @(posedge clk);
        #1 chk_on = 1'b1;          // R10 reset state is checked from here on
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R2 R3 R4 R5 R6 R7 R9: full sweep, negative short displacement
        regs(16'h1234, 16'h2000, 16'h0030, 16'h0400);
        for (int m = 0; m < 4; m++)
            for (int r = 0; r < 8; r++) step(1'b1, 2'(m), 3'(r), 8'h85, 8'h12);
        // R4: positive short displacement, high byte must not matter
        for (int r = 0; r < 8; r++) step(1'b1, 2'd1, 3'(r), 8'h7F, 8'hEE);
        // R11: idle with changing inputs, outputs must hold
        step(1'b0, 2'd2, 3'd0, 8'hAA, 8'h55);
        regs(16'h0001, 16'h0002, 16'h0003, 16'h0004);
        step(1'b0, 2'd3, 3'd6, 8'h11, 8'h22);
        step(1'b0, 2'd0, 3'd6, 8'h33, 8'h44);
        // R8: wrap-around sums
        regs(16'hFFF0, 16'hFF00, 16'h0020, 16'h8000);
        for (int m = 0; m < 3; m++)
            for (int r = 0; r < 8; r++) step(1'b1, 2'(m), 3'(r), 8'hFF, 8'hFF);
        // R3: direct address with registers that would otherwise matter
        step(1'b1, 2'd0, 3'd6, 8'h34, 8'hAB);
        step(1'b1, 2'd3, 3'd2, 8'h00, 8'h00);
        // Random traffic with gaps
        for (int n = 0; n < 3000; n++) begin
            regs(16'($urandom), 16'($urandom), 16'($urandom), 16'($urandom));
            step(($urandom % 4) != 0, 2'($urandom), 3'($urandom), 8'($urandom), 8'($urandom));
        end
        step(1'b0, 2'd0, 3'd0, 8'h00, 8'h00);
        @(negedge clk);
        @(posedge clk);
        finish_run();
    end
endmodule